// File: doc/BRIEF.md
# Page-Mode DRAM Sequencer with Column-First Refresh

This block sits between a simple host request port and a by-4 asynchronous DRAM with extended-data-out page access. Each host request carries an address, a write flag and a 4-bit write value, and is accepted with a valid/ready handshake. The block splits the address into a row part and a column part and puts both on one multiplexed address bus. It drives the active-low row strobe, column strobe, write enable and output enable. It also controls the direction of the 4-bit data path, which is brought out as separate drive-value, drive-enable and sample pins. Read results come back as a 4-bit value with a one-cycle valid pulse.

After an access the row stays open. A later request to the same row reuses it and only pulses the column strobe. A request to another row first closes the page for a minimum number of clocks. A free-running interval timer asks for refresh. The refresh closes any open page and then runs a column-before-row cycle, which needs no address. Writes always set up write enable before the column strobe falls, so the memory never drives the shared data pins while the controller does. All minimum timings are parameters counted in clocks.

Top module: `edo_dram_ctrl`

## Requirements
- R1: While reset is low, `dram_ras_n`, `dram_cas_n`, `dram_we_n` and `dram_oe_n` are 1, `dram_dq_oe` and `rsp_valid` are 0, and once reset is released with no refresh due `req_ready` is 1.
- R2: The row is `req_addr[ROW_W+COL_W-1:COL_W]` and the column is `req_addr[COL_W-1:0]`. The row sits on `dram_addr` when the row strobe falls and the column sits there when the column strobe falls. Bus bits above the part being driven are 0.
- R3: A read holds `dram_we_n` at 1 and `dram_oe_n` at 0 while the column strobe is low. It samples `dram_dq_in` at the end of the T_CAC-th cycle with the column strobe low and returns that value on `rsp_rdata` with `rsp_valid` high for exactly one cycle.
- R4: A write lowers `dram_we_n` and raises `dram_dq_oe` with `dram_dq_out` equal to `req_wdata` at least one cycle before the column strobe falls. Write enable and the address do not change in the cycle the column strobe falls.
- R5: A refresh lowers `dram_cas_n` at least one cycle before `dram_ras_n`, with `dram_we_n` at 1. It holds both low for T_REF_LOW cycles and then precharges. A refresh closes any open page, so the next access opens its row again.
- R6: An access to the row of the open page leaves `dram_ras_n` low and only pulses `dram_cas_n`.
- R7: `dram_oe_n` is 0 only during a read with both strobes low. `dram_dq_oe` is 1 only while `dram_we_n` is 0 and never while `dram_oe_n` is 0.
- R8: Counted from the clock edge that accepts a read, `rsp_valid` rises 1+T_CAC edges later on an open-page hit, T_RCD+1+T_CAC edges later from the idle state, and T_RP+T_RCD+1+T_CAC edges later on a page miss.
- R9: A refresh becomes due every REF_INT clocks. While one is due, `req_ready` is 0, so the gap between consecutive refresh cycles stays within one access of REF_INT.
- R10: Before any row strobe falls, `dram_ras_n` has been high for at least T_RP cycles.
- R11: Write data reaches the addressed cell, and later reads of that address return it, across page hits, page misses and refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W | Row in upper bits, column in lower bits |
| req_wdata | input | DQ_W | Write value |
| rsp_valid | output | 1 | One-cycle pulse with read result |
| rsp_rdata | output | DQ_W | Read result |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| dram_dq_oe | output | 1 | Controller drives the data pins |
| dram_dq_out | output | DQ_W | Value driven onto the data pins |
| dram_dq_in | input | DQ_W | Value sampled from the data pins |

## Verification
A read response is due a fixed number of edges after the accepting edge: 1+T_CAC on a page hit, T_RCD+1+T_CAC from idle, and T_RP added on a page miss. The bench records the number of the accepting edge and compares the edge count at the first `rsp_valid` it sees at a falling edge. Latency is only checked in a directed phase that ends well before the first refresh is due. The one exception is a read placed just after the first refresh, which must show the idle latency. In the random phase refreshes can delay responses, so the bench checks only the returned data there. A memory model samples the strobes on every rising edge and compares each falling edge of a strobe with the previous cycle's values. This is how it checks the column-first refresh order, the early write enable and the bus contents.

// File: rtl/edo_pkg.sv
package edo_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROW,
        ST_SETUP,
        ST_COL,
        ST_PAGE,
        ST_PRE,
        ST_REF_CAS,
        ST_REF_RAS
    } edo_state_e;

endpackage

// File: rtl/edo_addr_split.sv
module edo_addr_split #(
    parameter int unsigned ROW_W = 11,
    parameter int unsigned COL_W = 11,
    parameter int unsigned BUS_W = 11
) (
    input  logic [ROW_W+COL_W-1:0] addr,
    output logic [BUS_W-1:0]       row_bus,
    output logic [BUS_W-1:0]       col_bus
);

    localparam int unsigned ADDR_W = ROW_W + COL_W;

    generate
        if (BUS_W > ROW_W) begin : g_row_pad
            assign row_bus = {{(BUS_W-ROW_W){1'b0}}, addr[ADDR_W-1:COL_W]};
        end else begin : g_row_full
            assign row_bus = addr[ADDR_W-1:COL_W];
        end

        if (BUS_W > COL_W) begin : g_col_pad
            assign col_bus = {{(BUS_W-COL_W){1'b0}}, addr[COL_W-1:0]};
        end else begin : g_col_full
            assign col_bus = addr[COL_W-1:0];
        end
    endgenerate

endmodule

// File: rtl/edo_refresh_timer.sv
module edo_refresh_timer #(
    parameter int unsigned REF_INT = 1560
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ack,
    output logic pending
);

    localparam int unsigned     CNT_W  = (REF_INT > 2) ? $clog2(REF_INT) : 1;
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(REF_INT - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic             pend_d, pend_q;

    always_comb begin
        cnt_d  = cnt_q;
        pend_d = pend_q;
        if (ack) begin
            pend_d = 1'b0;
        end
        if (cnt_q == '0) begin
            cnt_d  = RELOAD;
            pend_d = 1'b1;
        end else begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= RELOAD;
            pend_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            pend_q <= pend_d;
        end
    end

    assign pending = pend_q;

endmodule

// File: rtl/edo_read_capture.sv
module edo_read_capture #(
    parameter int unsigned DQ_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            capture,
    input  logic [DQ_W-1:0] dq_in,
    output logic            rsp_valid,
    output logic [DQ_W-1:0] rsp_rdata
);

    logic            vld_d, vld_q;
    logic [DQ_W-1:0] dat_d, dat_q;

    always_comb begin
        vld_d = capture;
        dat_d = capture ? dq_in : dat_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
            dat_q <= '0;
        end else begin
            vld_q <= vld_d;
            dat_q <= dat_d;
        end
    end

    assign rsp_valid = vld_q;
    assign rsp_rdata = dat_q;

endmodule

// File: rtl/edo_dram_ctrl.sv
module edo_dram_ctrl
    import edo_pkg::*;
#(
    parameter int unsigned ROW_W     = 11,
    parameter int unsigned COL_W     = 11,
    parameter int unsigned DQ_W      = 4,
    parameter int unsigned T_RCD     = 2,
    parameter int unsigned T_CAC     = 2,
    parameter int unsigned T_RP      = 3,
    parameter int unsigned T_CSR     = 1,
    parameter int unsigned T_REF_LOW = 4,
    parameter int unsigned REF_INT   = 1560,
    localparam int unsigned ADDR_W   = ROW_W + COL_W,
    localparam int unsigned BUS_W    = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DQ_W-1:0]   req_wdata,
    output logic              rsp_valid,
    output logic [DQ_W-1:0]   rsp_rdata,
    output logic              dram_ras_n,
    output logic              dram_cas_n,
    output logic              dram_we_n,
    output logic              dram_oe_n,
    output logic [BUS_W-1:0]  dram_addr,
    output logic              dram_dq_oe,
    output logic [DQ_W-1:0]   dram_dq_out,
    input  logic [DQ_W-1:0]   dram_dq_in
);

    localparam int unsigned T_MAX01 = (T_RCD > T_CAC) ? T_RCD : T_CAC;
    localparam int unsigned T_MAX23 = (T_RP > T_CSR) ? T_RP : T_CSR;
    localparam int unsigned T_MAX0  = (T_MAX01 > T_MAX23) ? T_MAX01 : T_MAX23;
    localparam int unsigned T_MAX   = (T_MAX0 > T_REF_LOW) ? T_MAX0 : T_REF_LOW;
    localparam int unsigned CNT_W   = $clog2(T_MAX + 1);

    typedef struct packed {
        edo_state_e       state;
        logic [CNT_W-1:0] cnt;
        logic             ras_n;
        logic             cas_n;
        logic             we_n;
        logic             oe_n;
        logic [BUS_W-1:0] addr;
        logic             dq_oe;
        logic [DQ_W-1:0]  dq_out;
        logic             pend;
        logic             op_wr;
        logic [BUS_W-1:0] op_row;
        logic [BUS_W-1:0] op_col;
        logic [DQ_W-1:0]  op_data;
        logic [BUS_W-1:0] open_row;
    } ctl_t;

    localparam ctl_t CTL_RST = '{
        state:    ST_IDLE,
        cnt:      '0,
        ras_n:    1'b1,
        cas_n:    1'b1,
        we_n:     1'b1,
        oe_n:     1'b1,
        addr:     '0,
        dq_oe:    1'b0,
        dq_out:   '0,
        pend:     1'b0,
        op_wr:    1'b0,
        op_row:   '0,
        op_col:   '0,
        op_data:  '0,
        open_row: '0
    };

    function automatic logic [CNT_W-1:0] load_of(input int unsigned cycles);
        return CNT_W'(cycles - 1);
    endfunction

    ctl_t             ctl_d, ctl_q;
    logic [BUS_W-1:0] req_row_bus;
    logic [BUS_W-1:0] req_col_bus;
    logic             ref_pend;
    logic             ref_ack;
    logic             capture;
    logic             accept;

    edo_addr_split #(
        .ROW_W (ROW_W),
        .COL_W (COL_W),
        .BUS_W (BUS_W)
    ) u_split (
        .addr    (req_addr),
        .row_bus (req_row_bus),
        .col_bus (req_col_bus)
    );

    edo_refresh_timer #(
        .REF_INT (REF_INT)
    ) u_ref (
        .clk     (clk),
        .rst_n   (rst_n),
        .ack     (ref_ack),
        .pending (ref_pend)
    );

    edo_read_capture #(
        .DQ_W (DQ_W)
    ) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (capture),
        .dq_in     (dram_dq_in),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    assign req_ready = ((ctl_q.state == ST_IDLE) || (ctl_q.state == ST_PAGE)) && !ref_pend;
    assign accept    = req_valid && req_ready;

    always_comb begin
        ctl_d   = ctl_q;
        ref_ack = 1'b0;
        capture = 1'b0;

        if (accept) begin
            ctl_d.op_wr   = req_write;
            ctl_d.op_row  = req_row_bus;
            ctl_d.op_col  = req_col_bus;
            ctl_d.op_data = req_wdata;
        end

        unique case (ctl_q.state)
            ST_IDLE: begin
                if (ref_pend) begin
                    ctl_d.state = ST_REF_CAS;
                    ctl_d.cas_n = 1'b0;
                    ctl_d.cnt   = load_of(T_CSR);
                    ref_ack     = 1'b1;
                end else if (accept) begin
                    ctl_d.state    = ST_ROW;
                    ctl_d.ras_n    = 1'b0;
                    ctl_d.addr     = req_row_bus;
                    ctl_d.open_row = req_row_bus;
                    ctl_d.cnt      = load_of(T_RCD);
                end
            end

            ST_ROW: begin
                if (ctl_q.cnt != '0) begin
                    ctl_d.cnt = ctl_q.cnt - 1'b1;
                end else begin
                    ctl_d.state  = ST_SETUP;
                    ctl_d.addr   = ctl_q.op_col;
                    ctl_d.we_n   = !ctl_q.op_wr;
                    ctl_d.dq_oe  = ctl_q.op_wr;
                    ctl_d.dq_out = ctl_q.op_data;
                end
            end

            ST_SETUP: begin
                ctl_d.state = ST_COL;
                ctl_d.cas_n = 1'b0;
                ctl_d.oe_n  = ctl_q.op_wr;
                ctl_d.cnt   = load_of(T_CAC);
            end

            ST_COL: begin
                if (ctl_q.cnt != '0) begin
                    ctl_d.cnt = ctl_q.cnt - 1'b1;
                end else begin
                    capture     = !ctl_q.op_wr;
                    ctl_d.state = ST_PAGE;
                    ctl_d.cas_n = 1'b1;
                    ctl_d.oe_n  = 1'b1;
                    ctl_d.we_n  = 1'b1;
                    ctl_d.dq_oe = 1'b0;
                end
            end

            ST_PAGE: begin
                if (ref_pend) begin
                    ctl_d.state = ST_PRE;
                    ctl_d.ras_n = 1'b1;
                    ctl_d.cnt   = load_of(T_RP);
                end else if (accept) begin
                    if (req_row_bus == ctl_q.open_row) begin
                        ctl_d.state  = ST_SETUP;
                        ctl_d.addr   = req_col_bus;
                        ctl_d.we_n   = !req_write;
                        ctl_d.dq_oe  = req_write;
                        ctl_d.dq_out = req_wdata;
                    end else begin
                        ctl_d.state = ST_PRE;
                        ctl_d.ras_n = 1'b1;
                        ctl_d.pend  = 1'b1;
                        ctl_d.cnt   = load_of(T_RP);
                    end
                end
            end

            ST_PRE: begin
                if (ctl_q.cnt != '0) begin
                    ctl_d.cnt = ctl_q.cnt - 1'b1;
                end else if (ctl_q.pend) begin
                    ctl_d.state    = ST_ROW;
                    ctl_d.pend     = 1'b0;
                    ctl_d.ras_n    = 1'b0;
                    ctl_d.addr     = ctl_q.op_row;
                    ctl_d.open_row = ctl_q.op_row;
                    ctl_d.cnt      = load_of(T_RCD);
                end else if (ref_pend) begin
                    ctl_d.state = ST_REF_CAS;
                    ctl_d.cas_n = 1'b0;
                    ctl_d.cnt   = load_of(T_CSR);
                    ref_ack     = 1'b1;
                end else begin
                    ctl_d.state = ST_IDLE;
                end
            end

            ST_REF_CAS: begin
                if (ctl_q.cnt != '0) begin
                    ctl_d.cnt = ctl_q.cnt - 1'b1;
                end else begin
                    ctl_d.state = ST_REF_RAS;
                    ctl_d.ras_n = 1'b0;
                    ctl_d.cnt   = load_of(T_REF_LOW);
                end
            end

            ST_REF_RAS: begin
                if (ctl_q.cnt != '0) begin
                    ctl_d.cnt = ctl_q.cnt - 1'b1;
                end else begin
                    ctl_d.state = ST_PRE;
                    ctl_d.ras_n = 1'b1;
                    ctl_d.cas_n = 1'b1;
                    ctl_d.cnt   = load_of(T_RP);
                end
            end

            default: begin
                ctl_d = CTL_RST;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= CTL_RST;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign dram_ras_n  = ctl_q.ras_n;
    assign dram_cas_n  = ctl_q.cas_n;
    assign dram_we_n   = ctl_q.we_n;
    assign dram_oe_n   = ctl_q.oe_n;
    assign dram_addr   = ctl_q.addr;
    assign dram_dq_oe  = ctl_q.dq_oe;
    assign dram_dq_out = ctl_q.dq_out;

endmodule

// File: rtl/edo_dram_ctrl_chk.sv
module edo_dram_ctrl_chk #(
    parameter int unsigned BUS_W = 11,
    parameter int unsigned T_RP  = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ras_n,
    input logic             cas_n,
    input logic             we_n,
    input logic             oe_n,
    input logic [BUS_W-1:0] addr,
    input logic             dq_oe,
    input logic             rsp_valid
);

    localparam int unsigned HW = $clog2(T_RP + 2);

    logic [HW-1:0] hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cnt <= HW'(T_RP);
        end else if (!ras_n) begin
            hi_cnt <= '0;
        end else if (hi_cnt < HW'(T_RP)) begin
            hi_cnt <= hi_cnt + 1'b1;
        end
    end

    AST_EARLY_WE_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cas_n) && !ras_n) |-> ($stable(we_n) && $stable(addr))) else $error("early write"); // R4

    AST_WRITE_DRIVES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> dq_oe) else $error("write drive"); // R4

    AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> (oe_n && !we_n)) else $error("bus fight"); // R7

    AST_OE_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |-> (!cas_n && !ras_n && we_n)) else $error("oe misuse"); // R7

    AST_CBR_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ras_n) && !cas_n) |-> (!$past(cas_n) && we_n)) else $error("cbr order"); // R5

    AST_RSP_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid) else $error("rsp pulse"); // R3

    AST_PRECHARGE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (hi_cnt >= HW'(T_RP))) else $error("precharge"); // R10

endmodule

bind edo_dram_ctrl edo_dram_ctrl_chk #(
    .BUS_W (BUS_W),
    .T_RP  (T_RP)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ras_n     (dram_ras_n),
    .cas_n     (dram_cas_n),
    .we_n      (dram_we_n),
    .oe_n      (dram_oe_n),
    .addr      (dram_addr),
    .dq_oe     (dram_dq_oe),
    .rsp_valid (rsp_valid)
);

// File: tb/edo_dram_ctrl_tb.sv
module edo_dram_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int ROW_W      = 5;
    localparam int COL_W      = 4;
    localparam int ADDR_W     = ROW_W + COL_W;
    localparam int BUS_W      = 5;
    localparam int T_RCD      = 2;
    localparam int T_CAC      = 2;
    localparam int T_RP       = 3;
    localparam int T_CSR      = 1;
    localparam int T_REF_LOW  = 3;
    localparam int REF_INT    = 400;
    localparam int LAT_HIT    = 1 + T_CAC;
    localparam int LAT_IDLE   = T_RCD + 1 + T_CAC;
    localparam int LAT_MISS   = T_RP + LAT_IDLE;
    localparam int DEPTH      = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [3:0]        req_wdata = '0;
    logic              req_ready;
    logic              rsp_valid;
    logic [3:0]        rsp_rdata;
    logic              dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe;
    logic [BUS_W-1:0]  dram_addr;
    logic [3:0]        dram_dq_out;
    logic [3:0]        dram_dq_in;

    int n_checks = 0;
    int n_fails  = 0;
    int cyc      = 0;
    int rst_cyc  = 0;

    logic [3:0]        mem     [DEPTH];
    logic [3:0]        exp_mem [DEPTH];
    logic [ADDR_W-1:0] rd_idx = '0;
    logic [ROW_W-1:0]  m_row = '0;
    logic              p_ras = 1'b1, p_cas = 1'b1, p_we = 1'b1;
    int ref_cnt = 0, ras_rise = 0, fight_cnt = 0;
    int last_ref = -1, min_gap = 1000000, max_gap = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc++;

    edo_dram_ctrl #(
        .ROW_W (ROW_W), .COL_W (COL_W), .DQ_W (4),
        .T_RCD (T_RCD), .T_CAC (T_CAC), .T_RP (T_RP),
        .T_CSR (T_CSR), .T_REF_LOW (T_REF_LOW), .REF_INT (REF_INT)
    ) u_dut (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_ready (req_ready), .req_write (req_write),
        .req_addr (req_addr), .req_wdata (req_wdata),
        .rsp_valid (rsp_valid), .rsp_rdata (rsp_rdata),
        .dram_ras_n (dram_ras_n), .dram_cas_n (dram_cas_n),
        .dram_we_n (dram_we_n), .dram_oe_n (dram_oe_n),
        .dram_addr (dram_addr), .dram_dq_oe (dram_dq_oe),
        .dram_dq_out (dram_dq_out), .dram_dq_in (dram_dq_in)
    );

    function automatic logic [3:0] init_val(input int idx);
        return 4'((idx * 7) ^ (idx >> 4) ^ 5);
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // memory model: device answers on data pins while both strobes and OE are low
    assign dram_dq_in = (!dram_cas_n && !dram_oe_n) ? mem[rd_idx] : 4'h0;

    always @(posedge clk) begin
        if (!rst_n) begin
            p_ras = 1'b1; p_cas = 1'b1; p_we = 1'b1;
        end else begin
            if (p_ras && !dram_ras_n && dram_cas_n) begin
                m_row = dram_addr[ROW_W-1:0];
            end
            if (p_ras && !dram_ras_n && !dram_cas_n) begin
                ref_cnt++;
                chk(!p_cas && dram_we_n, "R5 cas-before-ras with we high", {p_cas, dram_we_n}, 1);
                if (last_ref >= 0) begin
                    if (cyc - last_ref > max_gap) max_gap = cyc - last_ref;
                    if (cyc - last_ref < min_gap) min_gap = cyc - last_ref;
                end
                last_ref = cyc;
            end
            if (!p_ras && dram_ras_n) ras_rise++;
            if (p_cas && !dram_cas_n && !dram_ras_n) begin
                chk(dram_addr[BUS_W-1:COL_W] == '0, "R2 column bus upper bits", int'(dram_addr), 0);
                if (!dram_we_n) begin
                    chk(!p_we && dram_dq_oe, "R4 we low before cas falls", {p_we, dram_dq_oe}, 1);
                    mem[{m_row, dram_addr[COL_W-1:0]}] = dram_dq_out;
                end else begin
                    rd_idx = {m_row, dram_addr[COL_W-1:0]};
                    chk(!dram_oe_n, "R3 oe low on read", int'(dram_oe_n), 0);
                end
            end
            p_ras = dram_ras_n; p_cas = dram_cas_n; p_we = dram_we_n;
        end
    end

    always @(negedge clk) begin
        if (rst_n && dram_dq_oe && !dram_oe_n) fight_cnt++;
    end

    task automatic issue(input bit wr, input logic [ADDR_W-1:0] a, input logic [3:0] d,
                         output int acc);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        while (!req_ready) @(negedge clk);
        acc = cyc + 1;
        if (wr) exp_mem[a] = d;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic do_read(input logic [ADDR_W-1:0] a, output logic [3:0] data, output int lat);
        int acc;
        issue(1'b0, a, 4'h0, acc);
        while (!rsp_valid) @(negedge clk);
        lat  = cyc - acc;
        data = rsp_rdata;
    endtask

    task automatic do_write(input logic [ADDR_W-1:0] a, input logic [3:0] d);
        int acc;
        issue(1'b1, a, d, acc);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        summary();
        $finish;
    end

    initial begin
        logic [3:0] d;
        int lat, rises;
        logic [ADDR_W-1:0] a;
        for (int i = 0; i < DEPTH; i++) begin
            mem[i] = init_val(i);
            exp_mem[i] = init_val(i);
        end
        void'($urandom(32'd20240611));

        repeat (3) @(negedge clk);
        chk(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n, "R1 strobes high in reset",
            {dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}, 15);
        chk(!dram_dq_oe && !rsp_valid, "R1 no drive no response in reset", {dram_dq_oe, rsp_valid}, 0);
        rst_n = 1'b1;
        rst_cyc = cyc;
        @(negedge clk);
        chk(req_ready, "R1 ready after reset", int'(req_ready), 1);

        // directed: open row 2 with a write, then hits
        a = {5'd2, 4'd3};
        do_write(a, 4'h5);
        rises = ras_rise;
        do_read(a, d, lat);
        chk(d == 4'h5, "R11 read back written value", d, 5);
        chk(lat == LAT_HIT, "R8 page hit latency", lat, LAT_HIT);
        chk(ras_rise == rises, "R6 row strobe stays low on hit", ras_rise, rises);

        a = {5'd2, 4'd9};
        do_read(a, d, lat);
        chk(d == exp_mem[a], "R3 read untouched cell", d, exp_mem[a]);
        chk(lat == LAT_HIT, "R8 second hit latency", lat, LAT_HIT);
        do_write(a, 4'hC);
        do_read(a, d, lat);
        chk(d == 4'hC, "R4 hit write then read", d, 12);

        a = {5'd7, 4'd1};
        do_read(a, d, lat);
        chk(d == exp_mem[a], "R2 page miss data", d, exp_mem[a]);
        chk(lat == LAT_MISS, "R8 R10 page miss latency", lat, LAT_MISS);

        while (ref_cnt == 0) @(negedge clk);
        repeat (12) @(negedge clk);
        chk(!dram_ras_n == 1'b0 && !dram_cas_n == 1'b0, "R5 strobes released after refresh",
            {dram_ras_n, dram_cas_n}, 3);
        do_read(a, d, lat);
        chk(lat == LAT_IDLE, "R5 refresh closed page, idle latency", lat, LAT_IDLE);
        chk(d == exp_mem[a], "R5 data after refresh", d, exp_mem[a]);

        // random phase
        for (int i = 0; i < 400; i++) begin
            logic [ADDR_W-1:0] ra;
            ra = {5'($urandom % 4), 4'($urandom % 16)};
            if (($urandom % 2) == 0) begin
                do_write(ra, 4'($urandom));
            end else begin
                do_read(ra, d, lat);
                chk(d == exp_mem[ra], "R11 random read data", d, exp_mem[ra]);
            end
        end
        repeat (20) @(negedge clk);

        chk(fight_cnt == 0, "R7 no contention cycles", fight_cnt, 0);
        chk(ref_cnt >= (cyc - rst_cyc) / REF_INT - 1 && ref_cnt <= (cyc - rst_cyc) / REF_INT,
            "R9 refresh count", ref_cnt, (cyc - rst_cyc) / REF_INT);
        chk(max_gap <= REF_INT + 16, "R9 max refresh gap", max_gap, REF_INT);
        chk(min_gap >= REF_INT - 16, "R9 min refresh gap", min_gap, REF_INT);
        summary();
        $finish;
    end

endmodule